// File: doc/BRIEF.md
# Compare flags and condition evaluator

This block compares two operands by forming the first minus the second internally. The operands themselves pass through untouched. From the difference it derives six status flags: zero, sign, carry (borrow), auxiliary carry, overflow and parity. A compare strobe loads these flags into a register, and they stay there until the next strobe.

A 4-bit condition selector picks one of sixteen predicates over the held flags. The predicates come in eight pairs. Each pair is a base test and its complement, and they cover single-flag, unsigned and signed relations. The chosen predicate drives two outputs: a one-bit taken signal, and a byte that is all ones when the predicate holds and all zeros when it does not.

The selector path is purely combinational from the flag register. After one compare, a pipeline can therefore evaluate any number of conditions without further latency. Instruction decode, register-file writeback and memory stores are left to the surrounding logic.

Top module: `cmp_cond_top`

## Requirements
- R1: When `cmp_en` is high at a rising clock edge, the flag outputs take the values of the current operands from that edge on. When `cmp_en` is low, the flag outputs are held, whatever the operands do.
- R2: The zero flag is 1 exactly when the operands are equal. The sign flag is the top bit of (a - b). The carry flag is 1 exactly when a < b as unsigned numbers.
- R3: The overflow flag is 1 exactly when the operand sign bits differ and the sign bit of (a - b) differs from the sign bit of a. For example, 0x7FFF against 0x8000 sets it.
- R4: The auxiliary flag is the borrow out of bit 3, which is 1 when a[3:0] < b[3:0] as unsigned numbers.
- R5: The parity flag is 1 when the low 8 bits of (a - b) contain an even number of ones.
- R6: Single-flag selector codes: 0 overflow set, 1 overflow clear, 2 carry set, 3 carry clear, 4 zero set, 5 zero clear, 8 sign set, 9 sign clear, 10 parity set, 11 parity clear. For every odd code, the predicate is the complement of the predicate of the even code below it.
- R7: Unsigned compound codes: 6 holds when carry OR zero is 1 (below or equal), and 7 holds when both are 0 (above).
- R8: Signed codes: 12 holds when sign XOR overflow is 1 (less), 13 when it is 0 (greater or equal), 14 when (sign XOR overflow) OR zero is 1 (less or equal), and 15 when that expression is 0 (greater).
- R9: `set_byte` is 0xFF when the selected predicate holds and 0x00 otherwise. `taken` is 1 exactly when `set_byte` is 0xFF. Both follow `cond_sel` with no clock delay.
- R10: While `rst_n` is low, all six flags are 0. With cleared flags, the odd selector codes give 0xFF and the even codes give 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_en | input | 1 | Load flags from the current operands |
| opnd_a | input | 16 | Minuend operand |
| opnd_b | input | 16 | Subtrahend operand |
| cond_sel | input | 4 | Predicate selector code |
| flag_zero | output | 1 | Held zero flag |
| flag_sign | output | 1 | Held sign flag |
| flag_carry | output | 1 | Held carry/borrow flag |
| flag_aux | output | 1 | Held borrow out of bit 3 |
| flag_ovf | output | 1 | Held signed overflow flag |
| flag_par | output | 1 | Held even-parity flag of low byte |
| set_byte | output | 8 | 0xFF or 0x00 from the selected predicate |
| taken | output | 1 | Selected predicate result |

## Verification
The bench builds the block with its default parameters: a 16-bit datapath, an 8-bit parity window and a 4-bit auxiliary nibble. These defaults put the 0x7FFF/0x8000 signed boundary, equal operands and nibble borrows within reach of short, hand-checked vectors. For every compare vector, all sixteen selector codes are swept against the held flags. This exercises each predicate pair in both polarities across signed and unsigned orderings. Directed steps cover the reset state, flag holding while the operands change, and the one-edge load timing.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;

    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } flags_t;

    // condition groups: selector bits [3:1]; selector bit 0 inverts
    typedef enum logic [2:0] {
        GRP_OVF  = 3'd0,
        GRP_CRY  = 3'd1,
        GRP_ZRO  = 3'd2,
        GRP_BEQ  = 3'd3,
        GRP_SGN  = 3'd4,
        GRP_PAR  = 3'd5,
        GRP_LT   = 3'd6,
        GRP_LE   = 3'd7
    } cond_grp_e;

endpackage

// File: rtl/cmp_flag_gen.sv
module cmp_flag_gen
    import cmp_cond_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PAR_W  = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output flags_t            flags
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] diff_ext;
    logic [NIB_W:0]  nib_diff;

    always_comb begin
        diff_ext  = {1'b0, opnd_a} - {1'b0, opnd_b};
        nib_diff  = {1'b0, opnd_a[NIB_W-1:0]} - {1'b0, opnd_b[NIB_W-1:0]};
        flags.cry = diff_ext[DATA_W];
        flags.zro = (diff_ext[MSB:0] == '0);
        flags.sgn = diff_ext[MSB];
        flags.aux = nib_diff[NIB_W];
        flags.ovf = (opnd_a[MSB] ^ opnd_b[MSB]) & (diff_ext[MSB] ^ opnd_a[MSB]);
        flags.par = ~^diff_ext[PAR_W-1:0];
    end

endmodule

// File: rtl/cmp_cond_eval.sv
module cmp_cond_eval
    import cmp_cond_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  flags_t           flags,
    input  logic [SEL_W-1:0] cond_sel,
    output logic             pred
);
    cond_grp_e grp;
    logic      base;

    always_comb begin
        grp  = cond_grp_e'(cond_sel[SEL_W-1:1]);
        base = 1'b0;
        unique case (grp)
            GRP_OVF: base = flags.ovf;
            GRP_CRY: base = flags.cry;
            GRP_ZRO: base = flags.zro;
            GRP_BEQ: base = flags.cry | flags.zro;
            GRP_SGN: base = flags.sgn;
            GRP_PAR: base = flags.par;
            GRP_LT:  base = flags.sgn ^ flags.ovf;
            GRP_LE:  base = (flags.sgn ^ flags.ovf) | flags.zro;
            default: base = 1'b0;
        endcase
        pred = base ^ cond_sel[0];
    end

endmodule

// File: rtl/cmp_cond_top.sv
module cmp_cond_top
    import cmp_cond_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PAR_W  = 8,
    parameter int NIB_W  = 4,
    parameter int SEL_W  = 4,
    parameter int SET_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [SEL_W-1:0]  cond_sel,
    output logic              flag_zero,
    output logic              flag_sign,
    output logic              flag_carry,
    output logic              flag_aux,
    output logic              flag_ovf,
    output logic              flag_par,
    output logic [SET_W-1:0]  set_byte,
    output logic              taken
);
    localparam int MSB = DATA_W - 1;

    flags_t next_flags;
    flags_t held_flags;
    logic   pred;

    cmp_flag_gen #(
        .DATA_W(DATA_W),
        .PAR_W (PAR_W),
        .NIB_W (NIB_W)
    ) u_flag_gen (
        .opnd_a(opnd_a),
        .opnd_b(opnd_b),
        .flags (next_flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_flags <= '0;
        end else if (cmp_en) begin
            held_flags <= next_flags;
        end
    end

    cmp_cond_eval #(
        .SEL_W(SEL_W)
    ) u_cond_eval (
        .flags   (held_flags),
        .cond_sel(cond_sel),
        .pred    (pred)
    );

    genvar gi;
    generate
        for (gi = 0; gi < SET_W; gi++) begin : g_set
            assign set_byte[gi] = pred;
        end
    endgenerate

    always_comb begin
        taken      = pred;
        flag_zero  = held_flags.zro;
        flag_sign  = held_flags.sgn;
        flag_carry = held_flags.cry;
        flag_aux   = held_flags.aux;
        flag_ovf   = held_flags.ovf;
        flag_par   = held_flags.par;
    end

    // R1: flags hold when no compare is issued
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_en |=> $stable({flag_zero, flag_sign, flag_carry, flag_aux, flag_ovf, flag_par}));

    // R2: equal operands give zero set and no borrow
    a_r2_equal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && opnd_a == opnd_b) |=> (flag_zero && !flag_carry));

    // R3: same-signed operands can never overflow
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_en && (opnd_a[MSB] == opnd_b[MSB])) |=> !flag_ovf);

    // R9: byte is all ones with taken, all zeros without
    a_r9_byte_form: assert property (@(posedge clk) disable iff (!rst_n)
        taken ? (set_byte == '1) : (set_byte == '0));

    // R10: reset leaves every flag clear
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |-> !(flag_zero | flag_sign | flag_carry | flag_aux | flag_ovf | flag_par));

endmodule

// File: tb/cmp_cond_top_bench.sv
module cmp_cond_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_en = 1'b0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [3:0]  cond_sel = '0;
    logic        flag_zero, flag_sign, flag_carry, flag_aux, flag_ovf, flag_par;
    logic [7:0]  set_byte;
    logic        taken;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmp_cond_top u_cmp_cond_top (
        .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .cond_sel(cond_sel),
        .flag_zero(flag_zero), .flag_sign(flag_sign), .flag_carry(flag_carry),
        .flag_aux(flag_aux), .flag_ovf(flag_ovf), .flag_par(flag_par),
        .set_byte(set_byte), .taken(taken)
    );

    // {a, b, expected flags as o s z a p c}
    localparam logic [37:0] VEC [NVEC] = '{
        {16'h2345, 16'h1234, 6'b000010},
        {16'h1234, 16'h2345, 6'b010101},
        {16'h1234, 16'hABCD, 6'b000101},
        {16'hABCD, 16'h1234, 6'b010010},
        {16'h7FFF, 16'h8000, 6'b110011},
        {16'h8000, 16'h7FFF, 6'b100100},
        {16'h1011, 16'h1011, 6'b001010},
        {16'h0001, 16'h0003, 6'b010101},
        {16'hABCD, 16'hDCBA, 6'b010001},
        {16'h0000, 16'h0001, 6'b010111}
    };

    function automatic logic exp_pred(input logic [3:0] c, input logic [5:0] f);
        logic o, s, z, p, cy;
        {o, s, z} = f[5:3];
        p  = f[1];
        cy = f[0];
        case (c)
            4'd0:  return o;                 // R6
            4'd1:  return !o;                // R6
            4'd2:  return cy;                // R6
            4'd3:  return !cy;               // R6
            4'd4:  return z;                 // R6
            4'd5:  return !z;                // R6
            4'd6:  return cy | z;            // R7
            4'd7:  return !cy && !z;         // R7
            4'd8:  return s;                 // R6
            4'd9:  return !s;                // R6
            4'd10: return p;                 // R6
            4'd11: return !p;                // R6
            4'd12: return s ^ o;             // R8
            4'd13: return !(s ^ o);          // R8
            4'd14: return (s ^ o) | z;       // R8
            default: return !((s ^ o) | z);  // R8
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] cur_flags();
        return {flag_ovf, flag_sign, flag_zero, flag_aux, flag_par, flag_carry};
    endfunction

    task automatic sweep(input logic [5:0] f, input string tag);
        for (int k = 0; k < 16; k++) begin
            logic e;
            @(negedge clk);
            cond_sel = 4'(k);
            #1;
            e = exp_pred(4'(k), f);
            chk((taken == e) && (set_byte == (e ? 8'hFF : 8'h00)),
                $sformatf("R6/R7/R8/R9 %s code=%0d", tag, k), {7'd0, taken, set_byte}, {7'd0, e, e ? 8'hFF : 8'h00});
        end
    endtask

    initial begin
        #(CLK_PERIOD*5000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(cur_flags() == 6'b0, "R10 flags in reset", {10'd0, cur_flags()}, 16'h0);
        cond_sel = 4'd4; #1;
        chk(set_byte == 8'h00, "R10 code4 in reset", {8'd0, set_byte}, 16'h0000);
        cond_sel = 4'd5; #1;
        chk(set_byte == 8'hFF, "R10 code5 in reset", {8'd0, set_byte}, 16'h00FF);
        @(negedge clk);
        rst_n = 1'b1;
        sweep(6'b0, "after reset");

        // table walk: R2 R3 R4 R5 then all codes
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            opnd_a = VEC[i][37:22];
            opnd_b = VEC[i][21:6];
            cmp_en = 1'b1;
            @(negedge clk);
            cmp_en = 1'b0;
            chk(cur_flags() == VEC[i][5:0],
                $sformatf("R2/R3/R4/R5 vec%0d %h-%h", i, VEC[i][37:22], VEC[i][21:6]),
                {10'd0, cur_flags()}, {10'd0, VEC[i][5:0]});
            sweep(VEC[i][5:0], $sformatf("vec%0d", i));
        end

        // R1: operands change with cmp_en low: flags held (last vector 0000-0001)
        @(negedge clk);
        opnd_a = 16'h5555;
        opnd_b = 16'h5555;
        repeat (3) @(negedge clk);
        chk(cur_flags() == 6'b010111, "R1 hold while disabled", {10'd0, cur_flags()}, 16'h0017);

        // R1: load takes effect at the strobed edge, not before
        cmp_en = 1'b1;
        #1;
        chk(cur_flags() == 6'b010111, "R1 no change before edge", {10'd0, cur_flags()}, 16'h0017);
        @(negedge clk);
        cmp_en = 1'b0;
        chk(cur_flags() == 6'b001010, "R1 R2 load equal operands", {10'd0, cur_flags()}, 16'h000A);

        // R3: boundary overflow directly via flag port
        opnd_a = 16'h7FFF;
        opnd_b = 16'hFFFF;
        cmp_en = 1'b1;
        @(negedge clk);
        cmp_en = 1'b0;
        // 7FFF-FFFF = 8000: borrow, sign set, overflow set, parity of 00 even, no nibble borrow
        chk(cur_flags() == 6'b110011, "R3 7FFF-FFFF", {10'd0, cur_flags()}, 16'h0033);
        sweep(6'b110011, "7FFF-FFFF");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule